// File: doc/BRIEF.md
# Secondary-Bus Parity Error Monitor

This block watches the secondary side of a bus bridge for parity trouble and turns what it sees into sticky status flags, an internal system-error pulse, a claim inhibit and corrupted parity on forwarded data. It receives per-cycle error pulses from the bus engine: an address/command parity error, a data parity error seen while the bridge reads as master, and the sampled error line while the bridge writes as master. It also receives the bridge's enable settings: parity error response, the bridge-control system-error enable and the command-register system-error enable. The block does not compute parity and does not run the bus protocol.

Three status flags latch the events. Software clears a flag by writing a one to its position. An address parity error forces a no-claim indication in the same cycle, so the decoder never accepts a cycle whose address may be wrong. This holds whatever the parity response setting is. When data coming from upstream is marked as carrying bad parity, every parity bit computed for the forwarded beats is inverted while the mark is held. The target then sees the corruption.

Top module: `sec_parity_monitor`

## Requirements
- R1: After reset is asserted (rst_n low), `sts_o` is 3'b000 and `serr_pulse_o` is 0.
- R2: `sts_o[0]` (detected parity error) is 1 from the clock edge that samples any of `adr_perr_i`, `rd_dperr_i`, `wr_perr_i` high. The enables and `is_master_i` have no effect on this flag.
- R3: `sts_o[1]` (master data parity error) becomes 1 at an edge that samples `is_master_i` and `perr_resp_en_i` high together with `rd_dperr_i` or `wr_perr_i` high. It is set in no other case.
- R4: `sts_o[2]` (signalled system error) becomes 1 at an edge that samples `adr_perr_i`, `cmd_serr_en_i`, `perr_resp_en_i` and `bctl_serr_en_i` all high. It is set in no other case.
- R5: `serr_pulse_o` is high for exactly the one cycle after each cycle in which the R3 or R4 condition holds. When both conditions hold in the same cycle, there is still only one such cycle.
- R6: `serr_pulse_o` stays low after a cycle in which neither the R3 nor the R4 condition holds, for example an address parity error with `cmd_serr_en_i` clear.
- R7: A set status bit stays set until an edge samples a 1 at its position in `w1c_i`. Zero bits of `w1c_i` leave their flags unchanged.
- R8: When a flag's set condition and its `w1c_i` bit are sampled at the same edge, the flag ends up set.
- R9: `no_claim_o` is high in the same cycle as `adr_perr_i` and follows it combinationally, whatever the value of `perr_resp_en_i`.
- R10: `beat_par_o` equals `beat_par_i` with every bit inverted while `up_bad_par_i` is high. Otherwise `beat_par_o` equals `beat_par_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_perr_i | input | 1 | Address/command parity error seen this cycle |
| rd_dperr_i | input | 1 | Data parity error on a read run by the bridge as master |
| wr_perr_i | input | 1 | Error line sampled active on a write run by the bridge as master |
| is_master_i | input | 1 | Bridge owns the secondary bus |
| perr_resp_en_i | input | 1 | Parity error response enable |
| bctl_serr_en_i | input | 1 | Bridge-control system-error enable |
| cmd_serr_en_i | input | 1 | Command-register system-error enable |
| w1c_i | input | 3 | Write-one-to-clear strobe, one bit per status flag |
| up_bad_par_i | input | 1 | Upstream data for this transfer is marked with bad parity |
| beat_par_i | input | NPAR | Parity bits computed for the current forwarded beat |
| sts_o | output | 3 | Sticky flags: [0] detected, [1] master data error, [2] signalled system error |
| serr_pulse_o | output | 1 | Internal system-error pulse |
| no_claim_o | output | 1 | Inhibits claiming the current cycle |
| beat_par_o | output | NPAR | Parity bits to drive for the forwarded beat |

## Verification
The assertions check on every cycle that each qualifying cause sets its flag at the next edge even when a clear arrives with it. They also check that flags hold without a clear, that a system-error pulse only appears alongside a latched master-data or signalled flag, and that no pulse follows a cycle with no enabled cause. The address-error claim inhibit and the parity inversion are also checked on every cycle. Only the bench scenarios can show the things that need a history: a clear really empties a flag, a mask of zeros changes nothing, simultaneous causes give one pulse rather than two, and a missing enable suppresses exactly the flag and pulse it should. The reset values are checked the same way.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int NSTS     = 3;
    localparam int STS_DPE  = 0;
    localparam int STS_MDPE = 1;
    localparam int STS_SSE  = 2;

    typedef struct packed {
        logic dpe;
        logic mdpe;
        logic sse;
    } spm_cause_t;

    typedef struct packed {
        logic [NSTS-1:0] sts;
        logic            serr;
    } spm_state_t;
endpackage

// File: rtl/spm_qualify.sv
module spm_qualify
    import spm_pkg::*;
(
    input  logic       adr_perr_i,
    input  logic       rd_dperr_i,
    input  logic       wr_perr_i,
    input  logic       is_master_i,
    input  logic       perr_resp_en_i,
    input  logic       bctl_serr_en_i,
    input  logic       cmd_serr_en_i,
    output spm_cause_t cause_o,
    output logic       no_claim_o
);
    logic data_err;

    always_comb begin
        data_err     = rd_dperr_i | wr_perr_i;
        // any error seen on the secondary bus is recorded
        cause_o.dpe  = adr_perr_i | data_err;
        // master-side data error counts only with response enabled
        cause_o.mdpe = is_master_i & perr_resp_en_i & data_err;
        // address error escalates only when all three enables agree
        cause_o.sse  = adr_perr_i & cmd_serr_en_i & perr_resp_en_i & bctl_serr_en_i;
        // a possibly corrupted address is never accepted
        no_claim_o   = adr_perr_i;
    end
endmodule

// File: rtl/spm_status_bank.sv
module spm_status_bank
    import spm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  spm_cause_t      cause_i,
    input  logic [NSTS-1:0] w1c_i,
    output logic [NSTS-1:0] sts_o,
    output logic            serr_o
);
    spm_state_t      st_d, st_q;
    logic [NSTS-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[STS_DPE]  = cause_i.dpe;
        set_vec[STS_MDPE] = cause_i.mdpe;
        set_vec[STS_SSE]  = cause_i.sse;
        st_d              = st_q;
        // set has priority over a clear in the same cycle
        st_d.sts          = (st_q.sts & ~w1c_i) | set_vec;
        // one pulse per cycle with any escalating cause
        st_d.serr         = cause_i.mdpe | cause_i.sse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o  = st_q.sts;
    assign serr_o = st_q.serr;
endmodule

// File: rtl/spm_par_force.sv
module spm_par_force #(
    parameter int NPAR = 4
) (
    input  logic            force_i,
    input  logic [NPAR-1:0] par_i,
    output logic [NPAR-1:0] par_o
);
    for (genvar g = 0; g < NPAR; g++) begin : g_lane
        assign par_o[g] = par_i[g] ^ force_i;
    end
endmodule

// File: rtl/sec_parity_monitor.sv
module sec_parity_monitor
    import spm_pkg::*;
#(
    parameter int NPAR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adr_perr_i,
    input  logic            rd_dperr_i,
    input  logic            wr_perr_i,
    input  logic            is_master_i,
    input  logic            perr_resp_en_i,
    input  logic            bctl_serr_en_i,
    input  logic            cmd_serr_en_i,
    input  logic [NSTS-1:0] w1c_i,
    input  logic            up_bad_par_i,
    input  logic [NPAR-1:0] beat_par_i,
    output logic [NSTS-1:0] sts_o,
    output logic            serr_pulse_o,
    output logic            no_claim_o,
    output logic [NPAR-1:0] beat_par_o
);
    spm_cause_t cause;

    spm_qualify u_qualify (
        .adr_perr_i     (adr_perr_i),
        .rd_dperr_i     (rd_dperr_i),
        .wr_perr_i      (wr_perr_i),
        .is_master_i    (is_master_i),
        .perr_resp_en_i (perr_resp_en_i),
        .bctl_serr_en_i (bctl_serr_en_i),
        .cmd_serr_en_i  (cmd_serr_en_i),
        .cause_o        (cause),
        .no_claim_o     (no_claim_o)
    );

    spm_status_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .w1c_i   (w1c_i),
        .sts_o   (sts_o),
        .serr_o  (serr_pulse_o)
    );

    spm_par_force #(.NPAR(NPAR)) u_force (
        .force_i (up_bad_par_i),
        .par_i   (beat_par_i),
        .par_o   (beat_par_o)
    );
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
    parameter int NPAR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adr_perr_i,
    input logic            rd_dperr_i,
    input logic            wr_perr_i,
    input logic            is_master_i,
    input logic            perr_resp_en_i,
    input logic            bctl_serr_en_i,
    input logic            cmd_serr_en_i,
    input logic [2:0]      w1c_i,
    input logic            up_bad_par_i,
    input logic [NPAR-1:0] beat_par_i,
    input logic [2:0]      sts_o,
    input logic            serr_pulse_o,
    input logic            no_claim_o,
    input logic [NPAR-1:0] beat_par_o
);
    // R2
    dpe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_perr_i || rd_dperr_i || wr_perr_i) |=> sts_o[0]);
    // R3
    mdpe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master_i && perr_resp_en_i && (rd_dperr_i || wr_perr_i)) |=> sts_o[1]);
    // R4
    sse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_perr_i && cmd_serr_en_i && perr_resp_en_i && bctl_serr_en_i) |=> sts_o[2]);
    // R5
    serr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse_o |-> (sts_o[1] || sts_o[2]));
    // R6
    serr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((is_master_i && perr_resp_en_i && (rd_dperr_i || wr_perr_i)) ||
          (adr_perr_i && cmd_serr_en_i && perr_resp_en_i && bctl_serr_en_i))
        |=> !serr_pulse_o);
    // R7
    hold_dpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[0] && !w1c_i[0]) |=> sts_o[0]);
    // R7
    hold_mdpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[1] && !w1c_i[1]) |=> sts_o[1]);
    // R7
    hold_sse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[2] && !w1c_i[2]) |=> sts_o[2]);
    // R9
    no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adr_perr_i |-> no_claim_o);
    // R10
    par_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_bad_par_i |-> (beat_par_o == ~beat_par_i));
    // R10
    par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_bad_par_i |-> (beat_par_o == beat_par_i));
endmodule

bind sec_parity_monitor spm_checker #(.NPAR(NPAR)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .adr_perr_i     (adr_perr_i),
    .rd_dperr_i     (rd_dperr_i),
    .wr_perr_i      (wr_perr_i),
    .is_master_i    (is_master_i),
    .perr_resp_en_i (perr_resp_en_i),
    .bctl_serr_en_i (bctl_serr_en_i),
    .cmd_serr_en_i  (cmd_serr_en_i),
    .w1c_i          (w1c_i),
    .up_bad_par_i   (up_bad_par_i),
    .beat_par_i     (beat_par_i),
    .sts_o          (sts_o),
    .serr_pulse_o   (serr_pulse_o),
    .no_claim_o     (no_claim_o),
    .beat_par_o     (beat_par_o)
);

// File: tb/sec_parity_monitor_bench.sv
module sec_parity_monitor_bench;
    localparam int NPAR = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            adr, rd, wr, mst, resp, bctl, cmd, upbad;
    logic [2:0]      w1c;
    logic [NPAR-1:0] par;
    logic [2:0]      sts;
    logic            serr, noclaim;
    logic [NPAR-1:0] par_out;

    int   n_chk = 0;
    int   n_err = 0;
    logic [2:0] m_sts = 3'b000;
    logic       m_serr = 1'b0;

    sec_parity_monitor #(.NPAR(NPAR)) u_sec_parity_monitor (
        .clk(clk), .rst_n(rst_n),
        .adr_perr_i(adr), .rd_dperr_i(rd), .wr_perr_i(wr),
        .is_master_i(mst), .perr_resp_en_i(resp),
        .bctl_serr_en_i(bctl), .cmd_serr_en_i(cmd),
        .w1c_i(w1c), .up_bad_par_i(upbad), .beat_par_i(par),
        .sts_o(sts), .serr_pulse_o(serr), .no_claim_o(noclaim),
        .beat_par_o(par_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        adr = 0; rd = 0; wr = 0; mst = 0; resp = 0; bctl = 0; cmd = 0;
        upbad = 0; w1c = 3'b000; par = '0;
    endtask

    // called at a negedge with inputs set; returns at the following negedge
    task automatic step();
        logic det, mde, sse;
        #1;
        chk("R9 no_claim", {31'd0, noclaim}, {31'd0, adr});
        chk("R10 parity", {28'd0, par_out}, {28'd0, (upbad ? ~par : par)});
        @(posedge clk);
        det    = adr | rd | wr;
        mde    = mst & resp & (rd | wr);
        sse    = adr & cmd & resp & bctl;
        m_sts  = (m_sts & ~w1c) | {sse, mde, det};
        m_serr = mde | sse;
        @(negedge clk);
        chk("R2 detected flag", {31'd0, sts[0]}, {31'd0, m_sts[0]});
        chk("R3 master data flag", {31'd0, sts[1]}, {31'd0, m_sts[1]});
        chk("R4 signalled flag", {31'd0, sts[2]}, {31'd0, m_sts[2]});
        chk("R5 serr pulse", {31'd0, serr}, {31'd0, m_serr});
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset sts", {29'd0, sts}, 32'd0);
        chk("R1 reset serr", {31'd0, serr}, 32'd0);
        rst_n = 1;

        // non-master read error: only detected flag
        idle(); rd = 1; resp = 1; step();
        chk("R2 non-master read", {29'd0, sts}, 32'd1);
        chk("R6 no serr", {31'd0, serr}, 32'd0);
        // clear mask on unset bits leaves flag
        idle(); w1c = 3'b110; step();
        chk("R7 zero-mask hold", {29'd0, sts}, 32'd1);
        idle(); w1c = 3'b001; step();
        chk("R7 clear", {29'd0, sts}, 32'd0);
        // master write error with response enabled
        idle(); wr = 1; mst = 1; resp = 1; step();
        chk("R3 master write", {29'd0, sts}, 32'd3);
        chk("R5 pulse", {31'd0, serr}, 32'd1);
        idle(); step();
        chk("R5 single cycle", {31'd0, serr}, 32'd0);
        chk("R7 hold", {29'd0, sts}, 32'd3);
        idle(); w1c = 3'b111; step();
        // master read error, response off
        idle(); rd = 1; mst = 1; step();
        chk("R3 resp off", {29'd0, sts}, 32'd1);
        chk("R6 resp off", {31'd0, serr}, 32'd0);
        // address error, all enables
        idle(); adr = 1; cmd = 1; resp = 1; bctl = 1; step();
        chk("R4 addr escalate", {29'd0, sts}, 32'd5);
        chk("R5 addr pulse", {31'd0, serr}, 32'd1);
        // address error, cmd enable clear
        idle(); adr = 1; resp = 1; bctl = 1; step();
        chk("R6 cmd off", {31'd0, serr}, 32'd0);
        // address error with response off: still no claim
        idle(); adr = 1; cmd = 1; bctl = 1; #1;
        chk("R9 resp off", {31'd0, noclaim}, 32'd1);
        step();
        // simultaneous causes with clear
        idle(); adr = 1; cmd = 1; resp = 1; bctl = 1; rd = 1; mst = 1; w1c = 3'b111;
        step();
        chk("R8 set wins", {29'd0, sts}, 32'd7);
        chk("R5 joint pulse", {31'd0, serr}, 32'd1);
        idle(); step();
        chk("R5 joint single", {31'd0, serr}, 32'd0);
        // parity forcing
        idle(); upbad = 1; par = 4'b1010; step();
        idle(); upbad = 1; par = 4'b0111; step();
        idle(); par = 4'b0110; step();

        // random traffic
        for (int i = 0; i < 600; i++) begin
            adr = ($urandom % 5) == 0; rd = ($urandom % 4) == 0;
            wr = ($urandom % 4) == 0; mst = $urandom; resp = $urandom;
            bctl = $urandom; cmd = $urandom; upbad = $urandom;
            par = NPAR'($urandom);
            w1c = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
            step();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule